// File: doc/BRIEF.md
# Cache Control Register Bank

This block is the software-visible control and status face of a small cache controller. A word-addressed bus with separate read and write strobes and a debug qualifier reaches a set of 32-bit registers. These registers hold the global configuration, the interface policy, the parameters of a maintenance operation and a write-one-to-clear interrupt status. A test window lets software inspect the cache array one word at a time.

The configuration word carries three group-open bits, a bypass control and a sticky cache lock. When a group-open bit is 0, writes to the registers of that group are dropped, but the registers can still be read. Once the cache lock is set, the bank accepts only debug accesses. Only a debug write or a reset clears the lock. Hardware error and page-fault events set status flags, and the interrupt output is the OR of those flags. The maintenance engine is outside this block: it sees the operation bits and the region bounds as outputs, and it reports completion through a done pulse. That pulse clears the operation word and both region bounds. The cache array is outside this block too. The bank drives the test address to it and receives the word stored at that address.

All register updates take effect on the rising clock edge that samples the strobe. Read data is combinational from the current register state. A test-data read advances the test address on the edge that ends the read.

Top module: `ccr_regfile`

## Requirements
- R1: After reset the registers read as follows: configuration (word at byte offset 0x04) is 0x1C, status (0x08) is 0, policy (0x0C) is 0x08, maintenance operation (0x10), region start (0x14), region end (0x18) and test address (0x1C) are 0, and `irq` is 0.
- R2: Configuration bit 4 opens the maintenance group (0x10, 0x14, 0x18), bit 3 opens the policy word (0x0C) and bit 2 opens the status word (0x08). While a group's bit is 0, writes to that group change nothing, and reads still return its contents.
- R3: Configuration bit 0 is a sticky cache lock, driven on `cfg_cache_lock`. Any accepted write with bit 0 at 1 sets it. Only a debug write with bit 0 at 0 clears it. While it is set, a non-debug access raises `bus_deny`, reads 0, writes nothing and leaves the test address unchanged.
- R4: Configuration bit 1 drives `cfg_bypass` (1 = all traffic cacheable, 0 = none).
- R5: Status bits are set on the edge after their event input is high: bit 4 by `ev_rd_err`, bit 3 by `ev_wr_err`, bit 1 by `ev_pgfault` and bit 0 by `ev_cfg_err`. On a read or write error event, bits 8:5 capture `ev_port`.
- R6: Writing 1s to the status word clears the matching bits in 8:0. A bit set by an event in the same cycle as its clear stays set.
- R7: `irq` is 1 exactly when any of status bits 4 down to 0 is 1.
- R8: Policy bits 5:0 are read/write and drive `pol_ctrl`. Bit 3 resets to 1 and the other bits reset to 0.
- R9: The maintenance operation word (bits 5:0), region start and region end drive `mnt_ops`, `mnt_start` and `mnt_end`. A `mnt_done` pulse clears all three. It also sets status bit 2, but only if operation bit 5 was 1 at that moment.
- R10: A read of 0x20 returns `tst_rdata`, the word at `tst_addr`. Each accepted read of 0x20 adds 4 to the test address.
- R11: Reserved bits read 0 and ignore writes. Writes to 0x20, to unmapped words or to unaligned addresses change nothing. Reads of unmapped or unaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_dbg | input | 1 | Access comes from the debugger |
| bus_rdata | output | 32 | Read data, combinational |
| bus_deny | output | 1 | Access refused by the cache lock |
| cfg_bypass | output | 1 | Cacheability control |
| cfg_cache_lock | output | 1 | Sticky cache lock |
| pol_ctrl | output | 6 | Interface policy bits |
| mnt_ops | output | 6 | Maintenance operation bits |
| mnt_start | output | 32 | Maintenance region start |
| mnt_end | output | 32 | Maintenance region end |
| mnt_done | input | 1 | Maintenance engine completion pulse |
| tst_addr | output | 32 | Test window address to the cache array |
| tst_rdata | input | 32 | Cache word at the test address |
| ev_rd_err | input | 1 | Read response error event |
| ev_wr_err | input | 1 | Write response error event |
| ev_port | input | PORT_W | Interface number of the error |
| ev_pgfault | input | 1 | MMU page fault event |
| ev_cfg_err | input | 1 | Configuration error event |
| irq | output | 1 | Interrupt request |

## Verification
The status word is driven with a seeded random mix of event pulses, random clear masks and their collisions. A bench model predicts every flag and the captured port number, which separates set-wins from clear-wins and shows whether the port field is overwritten or retained. Directed sequences walk each group lock closed and open, and set the cache lock with and without the debug qualifier, so that a lock applied to the wrong group or a clear accepted from a non-debug write shows up as a changed readback. The test window is read several times from a known address to confirm the step and the returned word. Completion pulses are given with and without the interrupt request bit, to tell the conditional status set apart from an unconditional one.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int DATA_W = 32;

  // word indices (byte offset / 4)
  localparam logic [5:0] IDX_CFG    = 6'h01;
  localparam logic [5:0] IDX_STAT   = 6'h02;
  localparam logic [5:0] IDX_POL    = 6'h03;
  localparam logic [5:0] IDX_MOPS   = 6'h04;
  localparam logic [5:0] IDX_MSTART = 6'h05;
  localparam logic [5:0] IDX_MEND   = 6'h06;
  localparam logic [5:0] IDX_TADDR  = 6'h07;
  localparam logic [5:0] IDX_TDATA  = 6'h08;

  // configuration field positions
  localparam int CFG_W       = 5;
  localparam int CFG_OPEN_MNT  = 4;
  localparam int CFG_OPEN_POL  = 3;
  localparam int CFG_OPEN_STAT = 2;
  localparam int CFG_BYPASS  = 1;
  localparam int CFG_LOCK    = 0;
  localparam logic [CFG_W-1:0] CFG_RESET = 5'b11100;

  localparam int POL_W = 6;
  localparam logic [POL_W-1:0] POL_RESET = 6'b001000;

  localparam int MOPS_W   = 6;
  localparam int MOPS_IRQ = 5;

  localparam int FLAG_W = 5;
  localparam int TEST_STEP = 4;

  typedef struct packed {
    logic cfg;
    logic stat;
    logic pol;
    logic mops;
    logic mstart;
    logic mend;
    logic taddr;
  } wr_strobe_t;

  // clear the written ones, then let set requests win
  function automatic logic [FLAG_W-1:0] w1c_merge(
    input logic [FLAG_W-1:0] cur,
    input logic [FLAG_W-1:0] clr,
    input logic [FLAG_W-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  // sticky lock: non-debug writes may only set, debug writes may set or clear
  function automatic logic sticky_next(
    input logic cur,
    input logic wbit,
    input logic dbg
  );
    return dbg ? wbit : (cur | wbit);
  endfunction

  function automatic logic [DATA_W-1:0] test_addr_next(
    input logic [DATA_W-1:0] cur
  );
    return cur + DATA_W'(TEST_STEP);
  endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dbg,
  input  logic              cache_lock,
  input  logic              open_mnt,
  input  logic              open_pol,
  input  logic              open_stat,
  output wr_strobe_t        we,
  output logic              tdata_rd,
  output logic              rd_ok,
  output logic              deny,
  output logic [ADDR_W-3:0] widx,
  output logic              aligned
);

  localparam int WIDX_W = ADDR_W - 2;

  logic wr_ok;

  function automatic logic hit(input logic [WIDX_W-1:0] w, input logic [5:0] idx);
    return w == WIDX_W'(idx);
  endfunction

  always_comb begin
    widx    = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    deny    = (wr_en | rd_en) & cache_lock & ~dbg;
    wr_ok   = wr_en & ~deny & aligned;
    rd_ok   = rd_en & ~deny & aligned;

    we.cfg    = wr_ok & hit(widx, IDX_CFG);
    we.stat   = wr_ok & hit(widx, IDX_STAT)   & open_stat;
    we.pol    = wr_ok & hit(widx, IDX_POL)    & open_pol;
    we.mops   = wr_ok & hit(widx, IDX_MOPS)   & open_mnt;
    we.mstart = wr_ok & hit(widx, IDX_MSTART) & open_mnt;
    we.mend   = wr_ok & hit(widx, IDX_MEND)   & open_mnt;
    we.taddr  = wr_ok & hit(widx, IDX_TADDR);
    tdata_rd  = rd_ok & hit(widx, IDX_TDATA);
  end

endmodule

// File: rtl/ccr_status.sv
module ccr_status
  import ccr_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [PORT_W+FLAG_W-1:0] wdata,
  input  logic                     ev_rd_err,
  input  logic                     ev_wr_err,
  input  logic                     ev_mnt,
  input  logic                     ev_pgfault,
  input  logic                     ev_cfg_err,
  input  logic [PORT_W-1:0]        ev_port,
  output logic [PORT_W+FLAG_W-1:0] stat,
  output logic                     irq
);

  logic [FLAG_W-1:0] flags_q, flags_d, set_vec, clr_vec;
  logic [PORT_W-1:0] port_q, port_d, port_clr;
  logic              capture;

  always_comb begin
    set_vec  = {ev_rd_err, ev_wr_err, ev_mnt, ev_pgfault, ev_cfg_err};
    clr_vec  = we ? wdata[FLAG_W-1:0] : '0;
    port_clr = we ? wdata[PORT_W+FLAG_W-1:FLAG_W] : '0;
    capture  = ev_rd_err | ev_wr_err;
    flags_d  = w1c_merge(flags_q, clr_vec, set_vec);
    port_d   = capture ? ev_port : (port_q & ~port_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      port_q  <= '0;
    end else begin
      flags_q <= flags_d;
      port_q  <= port_d;
    end
  end

  assign stat = {port_q, flags_q};
  assign irq  = |flags_q;

  a_r5_pgfault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pgfault |=> flags_q[1]);
  a_r5_port_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_err | ev_wr_err) |=> port_q == $past(ev_port));
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[0] && !ev_cfg_err) |=> !flags_q[0]);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[4] && ev_rd_err) |=> flags_q[4]);
  a_r7_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_rd_err | ev_wr_err | ev_mnt | ev_pgfault | ev_cfg_err));

endmodule

// File: rtl/ccr_maint.sv
module ccr_maint
  import ccr_pkg::*;
#(
  parameter int REGION_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_ops,
  input  logic                we_start,
  input  logic                we_end,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                done,
  output logic [MOPS_W-1:0]   ops,
  output logic [REGION_W-1:0] start_addr,
  output logic [REGION_W-1:0] end_addr,
  output logic                done_evt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops        <= '0;
      start_addr <= '0;
      end_addr   <= '0;
    end else if (done) begin
      ops        <= '0;
      start_addr <= '0;
      end_addr   <= '0;
    end else begin
      if (we_ops)   ops        <= wdata[MOPS_W-1:0];
      if (we_start) start_addr <= wdata[REGION_W-1:0];
      if (we_end)   end_addr   <= wdata[REGION_W-1:0];
    end
  end

  assign done_evt = done & ops[MOPS_IRQ];

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ops == '0) && (start_addr == '0) && (end_addr == '0));
  a_r9_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !we_ops) |=> $stable(ops));

endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_dbg,
  output logic [31:0]       bus_rdata,
  output logic              bus_deny,
  output logic              cfg_bypass,
  output logic              cfg_cache_lock,
  output logic [5:0]        pol_ctrl,
  output logic [5:0]        mnt_ops,
  output logic [31:0]       mnt_start,
  output logic [31:0]       mnt_end,
  input  logic              mnt_done,
  output logic [31:0]       tst_addr,
  input  logic [31:0]       tst_rdata,
  input  logic              ev_rd_err,
  input  logic              ev_wr_err,
  input  logic [PORT_W-1:0] ev_port,
  input  logic              ev_pgfault,
  input  logic              ev_cfg_err,
  output logic              irq
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam int STAT_W = PORT_W + FLAG_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [POL_W-1:0]  pol_q;
  logic [DATA_W-1:0] taddr_q;
  wr_strobe_t        we;
  logic              tdata_rd, rd_ok, aligned;
  logic [WIDX_W-1:0] widx;
  logic [STAT_W-1:0] stat;
  logic              mnt_evt;
  logic [MOPS_W-1:0] ops;
  logic [DATA_W-1:0] m_start, m_end;

  ccr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .dbg        (bus_dbg),
    .cache_lock (cfg_q[CFG_LOCK]),
    .open_mnt   (cfg_q[CFG_OPEN_MNT]),
    .open_pol   (cfg_q[CFG_OPEN_POL]),
    .open_stat  (cfg_q[CFG_OPEN_STAT]),
    .we         (we),
    .tdata_rd   (tdata_rd),
    .rd_ok      (rd_ok),
    .deny       (bus_deny),
    .widx       (widx),
    .aligned    (aligned)
  );

  ccr_status #(.PORT_W(PORT_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we.stat),
    .wdata      (bus_wdata[STAT_W-1:0]),
    .ev_rd_err  (ev_rd_err),
    .ev_wr_err  (ev_wr_err),
    .ev_mnt     (mnt_evt),
    .ev_pgfault (ev_pgfault),
    .ev_cfg_err (ev_cfg_err),
    .ev_port    (ev_port),
    .stat       (stat),
    .irq        (irq)
  );

  ccr_maint #(.REGION_W(DATA_W)) u_maint (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_ops     (we.mops),
    .we_start   (we.mstart),
    .we_end     (we.mend),
    .wdata      (bus_wdata),
    .done       (mnt_done),
    .ops        (ops),
    .start_addr (m_start),
    .end_addr   (m_end),
    .done_evt   (mnt_evt)
  );

  // configuration word: group-open bits, bypass, sticky lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (we.cfg) begin
      cfg_q[CFG_W-1:1] <= bus_wdata[CFG_W-1:1];
      cfg_q[CFG_LOCK]  <= sticky_next(cfg_q[CFG_LOCK], bus_wdata[CFG_LOCK], bus_dbg);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= POL_RESET;
    else if (we.pol) pol_q <= bus_wdata[POL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        taddr_q <= '0;
    else if (we.taddr) taddr_q <= bus_wdata;
    else if (tdata_rd) taddr_q <= test_addr_next(taddr_q);
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_ok && aligned) begin
      if      (widx == WIDX_W'(IDX_CFG))    bus_rdata = DATA_W'(cfg_q);
      else if (widx == WIDX_W'(IDX_STAT))   bus_rdata = DATA_W'(stat);
      else if (widx == WIDX_W'(IDX_POL))    bus_rdata = DATA_W'(pol_q);
      else if (widx == WIDX_W'(IDX_MOPS))   bus_rdata = DATA_W'(ops);
      else if (widx == WIDX_W'(IDX_MSTART)) bus_rdata = m_start;
      else if (widx == WIDX_W'(IDX_MEND))   bus_rdata = m_end;
      else if (widx == WIDX_W'(IDX_TADDR))  bus_rdata = taddr_q;
      else if (widx == WIDX_W'(IDX_TDATA))  bus_rdata = tst_rdata;
    end
  end

  assign cfg_bypass     = cfg_q[CFG_BYPASS];
  assign cfg_cache_lock = cfg_q[CFG_LOCK];
  assign pol_ctrl       = pol_q;
  assign mnt_ops        = ops;
  assign mnt_start      = m_start;
  assign mnt_end        = m_end;
  assign tst_addr       = taddr_q;

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_LOCK] && !(we.cfg && bus_dbg)) |=> cfg_q[CFG_LOCK]);
  a_r3_denied_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_deny && bus_wr) |=> ($stable(cfg_q) && $stable(pol_q) && $stable(taddr_q)));
  a_r2_pol_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cfg_q[CFG_OPEN_POL]) |=> $stable(pol_q));
  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    tdata_rd |=> (taddr_q == $past(taddr_q) + 32'd4));
  a_r10_no_step_when_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_deny && !bus_wr) |=> $stable(taddr_q));

endmodule

// File: tb/test_ccr_regfile.sv
`timescale 1ns/1ps
module test_ccr_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0, bus_dbg = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_deny, cfg_bypass, cfg_cache_lock, irq;
  logic [5:0]  pol_ctrl, mnt_ops;
  logic [31:0] mnt_start, mnt_end, tst_addr, tst_rdata;
  logic        mnt_done = 0;
  logic        ev_rd_err = 0, ev_wr_err = 0, ev_pgfault = 0, ev_cfg_err = 0;
  logic [3:0]  ev_port = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] cache_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  assign tst_rdata = cache_word(tst_addr);

  ccr_regfile i_ccr_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_dbg(bus_dbg),
    .bus_rdata(bus_rdata), .bus_deny(bus_deny), .cfg_bypass(cfg_bypass),
    .cfg_cache_lock(cfg_cache_lock), .pol_ctrl(pol_ctrl), .mnt_ops(mnt_ops),
    .mnt_start(mnt_start), .mnt_end(mnt_end), .mnt_done(mnt_done),
    .tst_addr(tst_addr), .tst_rdata(tst_rdata), .ev_rd_err(ev_rd_err),
    .ev_wr_err(ev_wr_err), .ev_port(ev_port), .ev_pgfault(ev_pgfault),
    .ev_cfg_err(ev_cfg_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic dbg);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_dbg = dbg;
    @(negedge clk);
    bus_wr = 0; bus_dbg = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic dbg,
                    output logic [31:0] v, output logic dn);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_dbg = dbg;
    #1 v = bus_rdata; dn = bus_deny;
    @(negedge clk);
    bus_rd = 0; bus_dbg = 0;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v; logic dn;
    rd(a, 1'b1, v, dn);
    chk(req, v, exp);
  endtask

  task automatic pulse(input int which, input logic [3:0] port);
    @(negedge clk);
    ev_port = port;
    case (which)
      0: ev_cfg_err = 1;
      1: ev_pgfault = 1;
      2: mnt_done   = 1;
      3: ev_wr_err  = 1;
      default: ev_rd_err = 1;
    endcase
    @(negedge clk);
    ev_cfg_err = 0; ev_pgfault = 0; mnt_done = 0; ev_wr_err = 0; ev_rd_err = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic dn;
    logic [4:0] m_flags;
    logic [3:0] m_port;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rchk("R1 cfg", 8'h04, 32'h1C);
    rchk("R1 stat", 8'h08, 32'h0);
    rchk("R1 pol", 8'h0C, 32'h08);
    rchk("R1 ops", 8'h10, 32'h0);
    rchk("R1 start", 8'h14, 32'h0);
    rchk("R1 end", 8'h18, 32'h0);
    rchk("R1 taddr", 8'h1C, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R8 policy, R11 reserved bits
    wr(8'h0C, 32'h3F, 0);
    rchk("R8 pol rw", 8'h0C, 32'h3F);
    chk("R8 pol out", {26'd0, pol_ctrl}, 32'h3F);
    wr(8'h0C, 32'hFFFF_FFC5, 0);
    rchk("R11 pol reserved", 8'h0C, 32'h05);

    // R4 bypass
    wr(8'h04, 32'h1E, 0);
    chk("R4 bypass on", {31'd0, cfg_bypass}, 32'h1);
    wr(8'h04, 32'hFFFF_FF1C, 0);
    chk("R4 bypass off", {31'd0, cfg_bypass}, 32'h0);
    rchk("R11 cfg reserved", 8'h04, 32'h1C);

    // R2 group locks
    wr(8'h04, 32'h14, 0);
    wr(8'h0C, 32'h00, 0);
    rchk("R2 pol locked", 8'h0C, 32'h05);
    wr(8'h04, 32'h18, 0);
    pulse(0, 4'h0);
    wr(8'h08, 32'h01, 0);
    rchk("R2 stat locked", 8'h08, 32'h01);
    wr(8'h04, 32'h0C, 0);
    wr(8'h14, 32'hABC, 0);
    rchk("R2 mnt locked", 8'h14, 32'h0);
    wr(8'h04, 32'h1C, 0);
    wr(8'h08, 32'h01, 0);
    rchk("R2 stat reopened", 8'h08, 32'h0);

    // R5 events and port capture, R7 irq
    pulse(4, 4'h5);
    rchk("R5 rd err port", 8'h08, 32'hB0);
    chk("R7 irq set", {31'd0, irq}, 32'h1);
    pulse(3, 4'h3);
    rchk("R5 wr err port", 8'h08, 32'h78);
    pulse(1, 4'h0);
    rchk("R5 pgfault", 8'h08, 32'h7A);
    wr(8'h08, 32'h1FF, 0);
    rchk("R6 clear all", 8'h08, 32'h0);
    chk("R7 irq clear", {31'd0, irq}, 32'h0);

    // R6 set wins over clear
    @(negedge clk);
    ev_pgfault = 1; bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'h02;
    @(negedge clk);
    ev_pgfault = 0; bus_wr = 0;
    rchk("R6 set wins", 8'h08, 32'h02);
    wr(8'h08, 32'h02, 0);

    // R9 maintenance
    wr(8'h14, 32'h1000, 0);
    wr(8'h18, 32'h2000, 0);
    wr(8'h10, 32'hFFFF_FFE1, 0);
    chk("R9 ops out", {26'd0, mnt_ops}, 32'h21);
    chk("R9 start out", mnt_start, 32'h1000);
    chk("R9 end out", mnt_end, 32'h2000);
    pulse(2, 4'h0);
    chk("R9 ops cleared", {26'd0, mnt_ops}, 32'h0);
    chk("R9 start cleared", mnt_start, 32'h0);
    chk("R9 end cleared", mnt_end, 32'h0);
    rchk("R9 done flag", 8'h08, 32'h04);
    wr(8'h08, 32'h04, 0);
    wr(8'h10, 32'h01, 0);
    pulse(2, 4'h0);
    rchk("R9 no flag without request", 8'h08, 32'h0);

    // R10 test window
    wr(8'h1C, 32'h100, 0);
    for (int k = 0; k < 3; k++) begin
      rd(8'h20, 0, v, dn);
      chk("R10 test data", v, cache_word(32'h100 + 32'(4 * k)));
    end
    rchk("R10 addr step", 8'h1C, 32'h10C);
    wr(8'h20, 32'hDEAD, 0);
    rchk("R11 tdata write ignored", 8'h1C, 32'h10C);
    rchk("R11 unmapped read", 8'h3C, 32'h0);
    wr(8'h0D, 32'h00, 0);
    rchk("R11 unaligned write", 8'h0C, 32'h05);

    // R3 cache lock
    wr(8'h04, 32'h1D, 0);
    chk("R3 lock set", {31'd0, cfg_cache_lock}, 32'h1);
    rd(8'h04, 0, v, dn);
    chk("R3 denied read", v, 32'h0);
    chk("R3 deny flag", {31'd0, dn}, 32'h1);
    wr(8'h0C, 32'h00, 0);
    rchk("R3 denied write", 8'h0C, 32'h05);
    rd(8'h20, 0, v, dn);
    rchk("R3 no step when denied", 8'h1C, 32'h10C);
    wr(8'h04, 32'h1C, 0);
    chk("R3 non-debug clear refused", {31'd0, cfg_cache_lock}, 32'h1);
    rd(8'h04, 1, v, dn);
    chk("R3 debug read", v, 32'h1D);
    chk("R3 debug not denied", {31'd0, dn}, 32'h0);
    wr(8'h04, 32'h1C, 1);
    chk("R3 debug clear", {31'd0, cfg_cache_lock}, 32'h0);

    // R5 R6 R7 random status traffic against a model
    m_flags = '0; m_port = '0;
    for (int it = 0; it < 300; it++) begin
      logic [31:0] e;
      logic [8:0] mask;
      logic do_w;
      logic [4:0] set;
      e = $urandom();
      mask = 9'($urandom());
      do_w = e[8];
      set = {e[0] & e[1], e[2] & e[3], 1'b0, e[9] & e[10], e[11] & e[12]};
      @(negedge clk);
      ev_rd_err = set[4]; ev_wr_err = set[3]; ev_pgfault = set[1]; ev_cfg_err = set[0];
      ev_port = e[7:4];
      bus_wr = do_w; bus_addr = 8'h08; bus_wdata = {23'd0, mask}; bus_dbg = 0;
      @(negedge clk);
      ev_rd_err = 0; ev_wr_err = 0; ev_pgfault = 0; ev_cfg_err = 0; bus_wr = 0;
      m_flags = (m_flags & ~(do_w ? mask[4:0] : 5'd0)) | set;
      if (set[4] | set[3]) m_port = e[7:4];
      else m_port = m_port & ~(do_w ? mask[8:5] : 4'd0);
      chk("R7 irq random", {31'd0, irq}, {31'd0, |m_flags});
      rchk("R6 status random", 8'h08, {23'd0, m_port, m_flags});
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule